// File: doc/BRIEF.md
# Repeating piecewise-linear waveform generator

This block plays a waveform made of straight-line segments. The segments are defined by a small table of signed 16-bit breakpoints. Between each pair of neighbouring breakpoints the block emits 2^n evenly spaced samples. The first of these samples is the lower breakpoint itself, and the rest are 2^n−1 interpolated points. The position inside a segment is an unsigned 16-bit fraction. It starts at zero and moves forward by 65535 >> n on each sample, with bit 0 forced high after each addition. When the position reaches 65535, it returns to zero and the block moves on to the next breakpoint pair. No separate end value is produced, because the end of one segment is the start of the next.

A host loads breakpoints through a write port while the block is idle. It then sets the table length, the exponent n, the sample period in clock ticks and the play mode, and pulses `start`. In continuous mode, the last segment runs from the final breakpoint back to the first, and the waveform repeats with no gap until `stop` is pulsed. In one-shot mode, the block walks the table once, emits the final breakpoint as its last sample, and then raises `done`.

Top module: `pwl_wavegen`

## Requirements
- R1: After reset, `sample` is 0 and `sample_vld`, `busy` and `done` are all low.
- R2: A table write is taken only while `busy` is low. A write issued while `busy` is high leaves the table unchanged.
- R3: Inside a segment from breakpoint L to breakpoint H, the j-th sample (j from 0 to 2^n−1) uses position p = 0 for j = 0 and p = j·2^(16−n) − 1 otherwise. The sample value is L + (((H − L)·p) >>> 16) in signed arithmetic, truncated to 16 bits.
- R4: Every segment produces exactly 2^n samples, and the first of them equals the segment's lower breakpoint.
- R5: After a segment completes, both indices advance by one. Each index wraps to 0 after the last valid entry, so in continuous mode the segment from entry len−1 to entry 0 is played.
- R6: In continuous mode the sequence repeats every len·2^n samples, with no missed sample periods.
- R7: In one-shot mode, segments 0 to len−2 are played, then one sample equal to entry len−1 is emitted. In the same cycle `done` rises and `busy` falls, and no further samples follow.
- R8: The first sample is valid on the second rising edge after `start` is sampled high. Later samples follow every max(`cfg_period`,1) cycles, and `sample_vld` is a single-cycle strobe when the period is above 1.
- R9: A table length below 2 makes every sample equal entry 0. In one-shot mode exactly one such sample is emitted before `done`.
- R10: A `stop` pulse during playback returns the block to idle, and no further samples are emitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Breakpoint write strobe |
| wr_addr | input | 5 | Breakpoint entry index |
| wr_data | input | 16 | Signed breakpoint value |
| cfg_len | input | 6 | Number of active breakpoints (values above 32 are clamped) |
| cfg_exp | input | 4 | Subdivision exponent n |
| cfg_period | input | 16 | Clock ticks per sample (0 is treated as 1) |
| cfg_once | input | 1 | 1 = one-shot, 0 = continuous |
| start | input | 1 | Begin playback from entry 0 (from idle or done) |
| stop | input | 1 | Abort playback and return to idle |
| sample | output | 16 | Current signed sample |
| sample_vld | output | 1 | New-sample strobe |
| busy | output | 1 | Playback in progress |
| done | output | 1 | One-shot playback finished |

## Verification
The bench sweeps every combination of exponent 0 to 3, table lengths 1, 2, 3 and 5, periods 1 and 3, and both modes. The breakpoint table is rotated between runs so that rising, falling, full-scale and zero-length slopes all appear. Exponent 0 shows that the segment start is emitted with no interior points. Higher exponents show the position sequence and the arithmetic shift on negative slopes. Lengths 1 and 2 separate the degenerate hold from the two-entry wrap. Continuous runs over two full loops show the last-to-first segment and the seamless repeat. One-shot runs show the final breakpoint and the quiet after `done`. Period 3 separates the strobe spacing from the back-to-back case. A write made mid-run is checked against a later playback.

// File: rtl/pwl_pkg.sv
package pwl_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_LAST = 2'd2,
        ST_DONE = 2'd3
    } pwl_state_e;
endpackage

// File: rtl/pwl_bp_table.sv
module pwl_bp_table #(
    parameter int W     = 16,
    parameter int DEPTH = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data,
    input  logic [AW-1:0] rd_a,
    input  logic [AW-1:0] rd_b,
    output logic [W-1:0]  q_a,
    output logic [W-1:0]  q_b
);
    logic [W-1:0] mem_q [DEPTH];

    for (genvar e = 0; e < DEPTH; e++) begin : g_entry
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                mem_q[e] <= '0;
            else if (wr_en && wr_addr == AW'(e))
                mem_q[e] <= wr_data;
        end
    end

    assign q_a = mem_q[rd_a];
    assign q_b = mem_q[rd_b];
endmodule

// File: rtl/pwl_frac_step.sv
module pwl_frac_step #(
    parameter int FRAC_W = 16,
    localparam int EXP_W = $clog2(FRAC_W)
) (
    input  logic [FRAC_W-1:0] pos,
    input  logic [EXP_W-1:0]  n,
    output logic [FRAC_W-1:0] pos_nxt,
    output logic              roll
);
    localparam logic [FRAC_W-1:0] FULL = '1;
    logic [FRAC_W-1:0] step;

    always_comb begin
        step    = FULL >> n;
        pos_nxt = (pos + step) | FRAC_W'(1);
        roll    = (pos_nxt == FULL);
    end
endmodule

// File: rtl/pwl_interp.sv
module pwl_interp #(
    parameter int W      = 16,
    parameter int FRAC_W = 16
) (
    input  logic [W-1:0]      y_lo,
    input  logic [W-1:0]      y_hi,
    input  logic [FRAC_W-1:0] frac,
    output logic [W-1:0]      y
);
    localparam int DW = W + 1;
    localparam int PW = DW + FRAC_W + 1;

    logic signed [DW-1:0] diff;
    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] ofs;
    logic signed [PW-1:0] sum;

    always_comb begin
        diff = $signed({y_hi[W-1], y_hi}) - $signed({y_lo[W-1], y_lo});
        prod = PW'(diff) * $signed({{(PW-FRAC_W){1'b0}}, frac});
        ofs  = prod >>> FRAC_W;
        sum  = $signed({{(PW-W){y_lo[W-1]}}, y_lo}) + ofs;
        y    = sum[W-1:0];
    end
endmodule

// File: rtl/pwl_wavegen.sv
module pwl_wavegen
    import pwl_pkg::*;
#(
    parameter int SAMPLE_W = 16,
    parameter int MAX_PTS  = 32,
    parameter int PERIOD_W = 16,
    parameter int FRAC_W   = 16,
    localparam int IDX_W   = $clog2(MAX_PTS),
    localparam int LEN_W   = IDX_W + 1,
    localparam int EXP_W   = $clog2(FRAC_W)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [IDX_W-1:0]    wr_addr,
    input  logic [SAMPLE_W-1:0] wr_data,
    input  logic [LEN_W-1:0]    cfg_len,
    input  logic [EXP_W-1:0]    cfg_exp,
    input  logic [PERIOD_W-1:0] cfg_period,
    input  logic                cfg_once,
    input  logic                start,
    input  logic                stop,
    output logic [SAMPLE_W-1:0] sample,
    output logic                sample_vld,
    output logic                busy,
    output logic                done
);
    typedef struct packed {
        pwl_state_e          st;
        logic [LEN_W-1:0]    len;
        logic [EXP_W-1:0]    n;
        logic                once;
        logic [PERIOD_W-1:0] per;
        logic [PERIOD_W-1:0] cnt;
        logic [FRAC_W-1:0]   pos;
        logic [IDX_W-1:0]    lo;
        logic [IDX_W-1:0]    hi;
        logic [SAMPLE_W-1:0] smp;
        logic                vld;
    } gen_regs_t;

    gen_regs_t r_d, r_q;

    logic [SAMPLE_W-1:0] y_lo, y_hi, y_mid;
    logic [FRAC_W-1:0]   pos_nxt;
    logic                roll;
    logic                busy_w;
    logic                multi;
    logic [IDX_W-1:0]    last_idx;
    logic [LEN_W-1:0]    len_in;
    logic [PERIOD_W-1:0] per_in;

    assign busy_w   = (r_q.st == ST_RUN) || (r_q.st == ST_LAST);
    assign multi    = (r_q.len >= LEN_W'(2));
    assign last_idx = IDX_W'(r_q.len - LEN_W'(1));
    assign len_in   = (cfg_len > LEN_W'(MAX_PTS)) ? LEN_W'(MAX_PTS) : cfg_len;
    assign per_in   = (cfg_period == '0) ? PERIOD_W'(1) : cfg_period;

    pwl_bp_table #(.W(SAMPLE_W), .DEPTH(MAX_PTS)) i_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en && !busy_w),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_a    (r_q.lo),
        .rd_b    (r_q.hi),
        .q_a     (y_lo),
        .q_b     (y_hi)
    );

    pwl_frac_step #(.FRAC_W(FRAC_W)) i_step (
        .pos     (r_q.pos),
        .n       (r_q.n),
        .pos_nxt (pos_nxt),
        .roll    (roll)
    );

    pwl_interp #(.W(SAMPLE_W), .FRAC_W(FRAC_W)) i_interp (
        .y_lo (y_lo),
        .y_hi (y_hi),
        .frac (r_q.pos),
        .y    (y_mid)
    );

    function automatic logic [IDX_W-1:0] wrap_inc(input logic [IDX_W-1:0] idx,
                                                  input logic [IDX_W-1:0] last);
        return (idx == last) ? '0 : idx + IDX_W'(1);
    endfunction

    always_comb begin
        r_d     = r_q;
        r_d.vld = 1'b0;
        unique case (r_q.st)
            ST_IDLE, ST_DONE: begin
                if (start) begin
                    r_d.st   = ST_RUN;
                    r_d.len  = len_in;
                    r_d.n    = cfg_exp;
                    r_d.once = cfg_once;
                    r_d.per  = per_in;
                    r_d.cnt  = '0;
                    r_d.pos  = '0;
                    r_d.lo   = '0;
                    r_d.hi   = (len_in >= LEN_W'(2)) ? IDX_W'(1) : '0;
                end else if (stop) begin
                    r_d.st = ST_IDLE;
                end
            end
            default: begin
                if (stop) begin
                    r_d.st = ST_IDLE;
                end else if (r_q.cnt != '0) begin
                    r_d.cnt = r_q.cnt - PERIOD_W'(1);
                end else begin
                    r_d.cnt = r_q.per - PERIOD_W'(1);
                    r_d.vld = 1'b1;
                    r_d.smp = y_mid;
                    if (r_q.st == ST_LAST) begin
                        r_d.st = ST_DONE;
                    end else if (!multi) begin
                        if (r_q.once) r_d.st = ST_DONE;
                    end else if (roll) begin
                        r_d.pos = '0;
                        if (r_q.once && r_q.hi == last_idx) begin
                            r_d.st = ST_LAST;
                            r_d.lo = r_q.hi;
                        end else begin
                            r_d.lo = wrap_inc(r_q.lo, last_idx);
                            r_d.hi = wrap_inc(r_q.hi, last_idx);
                        end
                    end else begin
                        r_d.pos = pos_nxt;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign sample     = r_q.smp;
    assign sample_vld = r_q.vld;
    assign busy       = busy_w;
    assign done       = (r_q.st == ST_DONE);

    // R3
    pos_odd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_w |-> (r_q.pos == '0 || r_q.pos[0]));

    // R5
    idx_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_RUN && multi) |-> (r_q.hi == wrap_inc(r_q.lo, last_idx)));

    // R5
    idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_w && multi) |-> (LEN_W'(r_q.lo) < r_q.len));

    // R8
    vld_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_vld && r_q.per > PERIOD_W'(1)) |=> !sample_vld);

    // R7
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(done)) |-> (!sample_vld && !busy));
endmodule

// File: tb/test_pwl_wavegen.sv
module test_pwl_wavegen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [5:0]  cfg_len = '0;
    logic [3:0]  cfg_exp = '0;
    logic [15:0] cfg_period = '0;
    logic        cfg_once = 1'b0;
    logic        start = 1'b0;
    logic        stop = 1'b0;
    logic [15:0] sample;
    logic        sample_vld, busy, done;

    int nchk = 0, nerr = 0, cyc = 0;
    int tbv[5];
    int base[5] = '{-32768, 32767, 100, -5000, 0};
    bit finished = 0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    pwl_wavegen i_pwl_wavegen (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .cfg_len(cfg_len), .cfg_exp(cfg_exp),
        .cfg_period(cfg_period), .cfg_once(cfg_once), .start(start),
        .stop(stop), .sample(sample), .sample_vld(sample_vld),
        .busy(busy), .done(done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int s16(input logic [15:0] v);
        return int'($signed(v));
    endfunction

    function automatic logic [15:0] expv(input int k, input int len, input int n, input bit os);
        int spc, seg, j, lo, hi, pos;
        longint d, p;
        if (len < 2) return 16'(tbv[0]);
        spc = 1 << n;
        seg = k / spc;
        j = k % spc;
        if (os && seg == len - 1) return 16'(tbv[len-1]);
        lo = seg % len;
        hi = (lo + 1) % len;
        pos = (j == 0) ? 0 : j * (1 << (16 - n)) - 1;
        d = longint'(tbv[hi]) - longint'(tbv[lo]);
        p = (d * longint'(pos)) >>> 16;
        return 16'(longint'(tbv[lo]) + p);
    endfunction

    task automatic load(input int len, input int rot);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            tbv[i]  = base[(i + rot) % 5];
            wr_en   = 1'b1;
            wr_addr = 5'(i);
            wr_data = 16'(tbv[i]);
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic run(input int len, input int n, input int per, input bit os, input bit poke);
        int nsamp, prev, t, pe;
        string tag;
        pe = (per == 0) ? 1 : per;
        if (os) nsamp = (len < 2) ? 1 : (len - 1) * (1 << n) + 1;
        else    nsamp = (len < 2) ? 4 : 2 * len * (1 << n);
        tag = (len < 2) ? "R9" : (os ? "R3/R4/R7" : "R3/R4/R5/R6");
        cfg_len = 6'(len); cfg_exp = 4'(n); cfg_period = 16'(per); cfg_once = os;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        prev = cyc;
        for (int k = 0; k < nsamp; k++) begin
            t = 0;
            do begin
                @(negedge clk);
                wr_en = 1'b0;
                t++;
            end while (!sample_vld && t < 2000);
            chk(sample_vld, "R8 sample timeout", t, pe);
            // R8 spacing between strobes
            chk((cyc - prev) == ((k == 0) ? 1 : pe), "R8 gap", cyc - prev, (k == 0) ? 1 : pe);
            prev = cyc;
            chk(sample == expv(k, len, n, os), tag, s16(sample), s16(expv(k, len, n, os)));
            if (poke && k == 0) begin
                // R2: write while busy must be dropped
                chk(busy == 1'b1, "R2 busy during run", busy, 1);
                wr_en = 1'b1; wr_addr = 5'd0; wr_data = 16'h1234;
            end
        end
        if (os) begin
            // R7 completion flags with final sample
            chk(done == 1'b1 && busy == 1'b0, "R7 done/busy", {done, busy}, 2);
            for (int i = 0; i < 3 * pe + 5; i++) begin
                @(negedge clk);
                chk(!sample_vld, "R7 quiet after done", sample_vld, 0);
            end
        end else begin
            @(negedge clk);
            stop = 1'b1;
            @(negedge clk);
            stop = 1'b0;
            for (int i = 0; i < 10; i++) begin
                @(negedge clk);
                chk(!sample_vld && !busy, "R10 stopped", {sample_vld, busy}, 0);
            end
        end
        @(negedge clk);
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            nerr++;
            nchk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

    initial begin
        int rot;
        rot = 0;
        repeat (3) @(negedge clk);
        // R1 reset values
        chk(sample == 16'd0, "R1 sample", s16(sample), 0);
        chk(!sample_vld && !busy && !done, "R1 flags", {sample_vld, busy, done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!sample_vld && !busy && !done, "R1 flags after release", {sample_vld, busy, done}, 0);

        for (int os = 0; os < 2; os++)
            for (int n = 0; n < 4; n++)
                for (int li = 0; li < 4; li++)
                    for (int pi = 0; pi < 2; pi++) begin
                        int len;
                        len = (li == 0) ? 1 : (li == 1) ? 2 : (li == 2) ? 3 : 5;
                        load(len, rot);
                        rot = (rot + 1) % 5;
                        run(len, n, (pi == 0) ? 1 : 3, os[0], 1'b0);
                    end

        // R2: mid-run write ignored, later idle write accepted
        load(3, 2);
        run(3, 1, 3, 1'b0, 1'b1);
        run(3, 0, 1, 1'b1, 1'b0);
        load(3, 4);
        run(3, 2, 1, 1'b1, 1'b0);
        // period 0 behaves as 1
        run(2, 1, 0, 1'b0, 1'b0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule